// File: doc/BRIEF.md
# Signed Averaging Add/Subtract Unit

This block computes the signed average of two operands: either half their sum or half their difference. The halving uses one of four fixed-point rounding rules, chosen per operation. The element width (8, 16, 32 or 64 bits) is also chosen per operation. The sum or difference is formed with one guard bit above the element width, so the carry out of the top bit is never lost before the halving shift.

The second operand has three possible sources: a vector element, a scalar, or a 5-bit immediate that is sign-extended. The immediate form only ever adds. Results wrap and never saturate. The answer is registered and appears one clock after the input strobe, together with an output strobe. The surrounding vector datapath issues one element per strobe and collects the results.

Top module: `savg_unit`

## Requirements
- R1: The element result equals the full-precision value `a + b` (or `a - b`) computed on W+1 bits, shifted right arithmetically by one, plus a rounding increment of 0 or 1. No carry is lost at any width: 32-bit MAX+MAX gives 0x7FFFFFFF, and 64-bit MIN+MIN gives 0x8000000000000000.
- R2: With `round_mode` = 0 (nearest, ties up), the increment equals bit 0 of the full-precision value.
- R3: With `round_mode` = 1 (nearest, ties to even), the increment is bit 0 AND bit 1 of the full-precision value. Whenever bit 0 is 1, the result LSB is 0.
- R4: With `round_mode` = 2 (truncate), the increment is always 0.
- R5: With `round_mode` = 3 (jam to odd), the increment is bit 0 AND NOT bit 1. Whenever bit 0 is 1, the result LSB is 1.
- R6: `width_sel` 0/1/2/3 selects 8/16/32/64-bit elements. Only the low W bits of each operand take part. The W-bit result is sign-extended to 64 bits on `result`.
- R7: Overflow wraps silently and is never saturated. A 32-bit subtract of 0x7FFFFFFF minus 0x80000000 with mode 0 yields 0xFFFFFFFF80000000. A 64-bit subtract of MIN minus MAX with mode 0 yields 0x8000000000000001.
- R8: `src_sel` 0 takes operand B from `opb_vec`, 1 from `opb_scalar`, and 2 from `imm` sign-extended. Code 3 behaves as 0.
- R9: With `src_sel` = 2 the unit always adds, whatever the value of `op_sub`.
- R10: `out_valid` is `in_valid` delayed by one clock. `result` loads only on a clock where `in_valid` is 1 and holds its value otherwise.
- R11: `rst_n` low clears `out_valid` at once, without waiting for a clock edge. The internal reset is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 1 = average of difference, 0 = of sum |
| width_sel | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 |
| round_mode | input | 2 | Rounding rule (see R2 to R5) |
| src_sel | input | 2 | Operand B source (see R8) |
| opa | input | 64 | Operand A |
| opb_vec | input | 64 | Operand B, vector element source |
| opb_scalar | input | 64 | Operand B, scalar source |
| imm | input | 5 | Signed immediate for operand B |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Sign-extended element result |

## Verification
The hardest case to provoke is a wrap through the guard bit in the 64-bit element. There the true sum of two extreme operands needs 65 bits, and only a design that keeps that bit returns the correct sign after halving. The same difficulty appears at every width when the shifted-out bit is 1 and ties-to-even or jam-to-odd rounding is active. The stimulus drives each rounding mode against the four extreme pairs MAX+MAX, MIN+MIN, MAX−MIN and MIN−MAX at all four widths, in both directions. Pseudo-random pairs are added, with odd sums present, and the results are compared against an independent wide-integer model.

// File: rtl/savg_pkg.sv
package savg_pkg;
  localparam int LANES  = 4;
  localparam int MAX_W  = 8 << (LANES - 1);
  localparam int IMM_W  = 5;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_DOWN      = 2'd2,
    RM_ODD       = 2'd3
  } round_mode_e;

  typedef enum logic [1:0] {
    SRC_VEC    = 2'd0,
    SRC_SCALAR = 2'd1,
    SRC_IMM    = 2'd2,
    SRC_ALT    = 2'd3
  } opb_src_e;
endpackage

// File: rtl/savg_rst_sync.sv
module savg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  // asserts asynchronously, releases on the second clock edge (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/savg_opb_sel.sv
module savg_opb_sel
  import savg_pkg::*;
(
  input  opb_src_e           src,
  input  logic               sub_req,
  input  logic [MAX_W-1:0]   b_vec,
  input  logic [MAX_W-1:0]   b_scalar,
  input  logic [IMM_W-1:0]   imm,
  output logic [MAX_W-1:0]   b_eff,
  output logic               sub_eff
);
  logic [MAX_W-1:0] imm_ext;

  assign imm_ext = {{(MAX_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    b_eff   = b_vec;
    sub_eff = sub_req;
    case (src)
      SRC_SCALAR: b_eff = b_scalar;
      SRC_IMM: begin
        b_eff   = imm_ext;
        sub_eff = 1'b0;   // immediate form is add-only (R9)
      end
      default: b_eff = b_vec;  // SRC_VEC and SRC_ALT (R8)
    endcase
  end
endmodule

// File: rtl/savg_round.sv
module savg_round
  import savg_pkg::*;
(
  input  round_mode_e mode,
  input  logic        drop_bit,
  input  logic        keep_lsb,
  output logic        inc
);
  always_comb begin
    case (mode)
      RM_NEAR_UP:   inc = drop_bit;               // R2
      RM_NEAR_EVEN: inc = drop_bit & keep_lsb;    // R3
      RM_DOWN:      inc = 1'b0;                   // R4
      default:      inc = drop_bit & ~keep_lsb;   // R5
    endcase
  end
endmodule

// File: rtl/savg_lane.sv
module savg_lane
  import savg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             sub,
  input  round_mode_e      mode,
  output logic [MAX_W-1:0] res
);
  localparam int XW = W + 1;

  logic [XW-1:0] a_x;
  logic [XW-1:0] b_x;
  logic [XW-1:0] full;
  logic [W-1:0]  half;
  logic [W-1:0]  elem;
  logic          inc;

  // guard bit keeps the carry across the halving shift (R1)
  assign a_x  = {a[W-1], a};
  assign b_x  = {b[W-1], b};
  assign full = sub ? (a_x - b_x) : (a_x + b_x);
  assign half = full[XW-1:1];

  savg_round u_round (
    .mode     (mode),
    .drop_bit (full[0]),
    .keep_lsb (full[1]),
    .inc      (inc)
  );

  // wraps to W bits, no saturation (R7)
  assign elem = half + W'(inc);

  generate
    if (W < MAX_W) begin : g_ext
      assign res = {{(MAX_W-W){elem[W-1]}}, elem};
    end else begin : g_full
      assign res = elem;
    end
  endgenerate

  always_comb begin
    if (mode == RM_NEAR_EVEN && full[0]) begin
      assert_tie_even_R3: assert (elem[0] == 1'b0);
    end
    if (mode == RM_ODD && full[0]) begin
      assert_jam_odd_R5: assert (elem[0] == 1'b1);
    end
    if (mode == RM_DOWN) begin
      assert_truncate_R4: assert (elem == half);
    end
    if (mode == RM_NEAR_UP && !full[0]) begin
      assert_exact_R2: assert (elem == half);
    end
  end
endmodule

// File: rtl/savg_unit.sv
module savg_unit
  import savg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic [1:0]       width_sel,
  input  logic [1:0]       round_mode,
  input  logic [1:0]       src_sel,
  input  logic [63:0]      opa,
  input  logic [63:0]      opb_vec,
  input  logic [63:0]      opb_scalar,
  input  logic [4:0]       imm,
  output logic             out_valid,
  output logic [63:0]      result
);
  logic             rst_s_n;
  logic [MAX_W-1:0] b_eff;
  logic             sub_eff;
  logic [MAX_W-1:0] lane_res [LANES];
  logic             vld_d, vld_q;
  logic [MAX_W-1:0] res_d, res_q;

  savg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  savg_opb_sel u_opb_sel (
    .src      (opb_src_e'(src_sel)),
    .sub_req  (op_sub),
    .b_vec    (opb_vec),
    .b_scalar (opb_scalar),
    .imm      (imm),
    .b_eff    (b_eff),
    .sub_eff  (sub_eff)
  );

  // one lane per element width, 8 << i bits (R6)
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int LW = 8 << i;
      savg_lane #(.W(LW)) u_lane (
        .a    (opa[LW-1:0]),
        .b    (b_eff[LW-1:0]),
        .sub  (sub_eff),
        .mode (round_mode_e'(round_mode)),
        .res  (lane_res[i])
      );
    end
  endgenerate

  // next-state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = lane_res[width_sel];
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) res_q <= res_d;
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> !out_valid);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> $stable(result));
  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_s_n |-> !out_valid);
endmodule

// File: tb/savg_unit_bench.sv
module savg_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        op_sub;
  logic [1:0]  width_sel;
  logic [1:0]  round_mode;
  logic [1:0]  src_sel;
  logic [63:0] opa, opb_vec, opb_scalar;
  logic [4:0]  imm;
  logic        out_valid;
  logic [63:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  savg_unit u_savg_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .width_sel(width_sel), .round_mode(round_mode), .src_sel(src_sel),
    .opa(opa), .opb_vec(opb_vec), .opb_scalar(opb_scalar), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  typedef struct packed {
    logic        sub;
    logic [1:0]  wsel;
    logic [1:0]  rm;
    logic [1:0]  src;
    logic [63:0] a;
    logic [63:0] bv;
    logic [63:0] bs;
    logic [4:0]  imm;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 2'd0, 64'd5, 64'd2, 64'd0, 5'd0, 64'd4},                    // 0 R2
    '{1'b0, 2'd0, 2'd1, 2'd0, 64'd5, 64'd0, 64'd0, 5'd0, 64'd2},                    // 1 R3
    '{1'b0, 2'd0, 2'd1, 2'd0, 64'd5, 64'd2, 64'd0, 5'd0, 64'd4},                    // 2 R3
    '{1'b0, 2'd0, 2'd2, 2'd0, 64'd5, 64'd2, 64'd0, 5'd0, 64'd3},                    // 3 R4
    '{1'b0, 2'd0, 2'd3, 2'd0, 64'd5, 64'd2, 64'd0, 5'd0, 64'd3},                    // 4 R5
    '{1'b0, 2'd0, 2'd3, 2'd0, 64'd5, 64'd0, 64'd0, 5'd0, 64'd3},                    // 5 R5
    '{1'b1, 2'd1, 2'd0, 2'd0, 64'hFFFD, 64'd2, 64'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFE}, // 6 R1
    '{1'b0, 2'd2, 2'd0, 2'd0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 64'd0, 5'd0, 64'h7FFF_FFFF}, // 7 R1
    '{1'b1, 2'd2, 2'd0, 2'd0, 64'h7FFF_FFFF, 64'h8000_0000, 64'd0, 5'd0, 64'hFFFF_FFFF_8000_0000}, // 8 R7
    '{1'b0, 2'd3, 2'd0, 2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 5'd0,
      64'h8000_0000_0000_0000},                                                      // 9 R1
    '{1'b1, 2'd3, 2'd0, 2'd0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 5'd0,
      64'h8000_0000_0000_0001},                                                      // 10 R7
    '{1'b1, 2'd0, 2'd0, 2'd2, 64'd10, 64'd0, 64'd0, 5'h1C, 64'd3},                  // 11 R9
    '{1'b0, 2'd1, 2'd2, 2'd1, 64'd100, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 64'd49}, // 12 R8
    '{1'b0, 2'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF01, 64'h1234_5678_9ABC_DE03, 64'd0, 5'd0,
      64'd2},                                                                         // 13 R6
    '{1'b0, 2'd0, 2'd2, 2'd3, 64'd8, 64'd4, 64'd100, 5'd0, 64'd6},                  // 14 R8
    '{1'b0, 2'd0, 2'd0, 2'd0, 64'h80, 64'h80, 64'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FF80}  // 15 R6
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7, 9: return "R1";
      8, 10: return "R7";
      11: return "R9";
      12, 14: return "R8";
      default: return "R6";
    endcase
  endfunction

  function automatic string rm_tag(input logic [1:0] rm);
    case (rm)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic signed [65:0] sext66(input logic [63:0] v, input int w);
    logic [65:0] t;
    t = {2'b00, v} << (66 - w);
    return $signed(t) >>> (66 - w);
  endfunction

  // behavioural model built from R1 to R9
  function automatic logic [63:0] ref_avg(input logic sub, input logic [1:0] wsel,
      input logic [1:0] rm, input logic [1:0] src, input logic [63:0] a,
      input logic [63:0] bv, input logic [63:0] bs, input logic [4:0] im);
    int w;
    logic [63:0] b;
    logic        s;
    logic signed [65:0] v, q, r;
    logic inc;
    w = 8 << wsel;
    s = sub;
    b = bv;
    if (src == 2'd1) b = bs;
    if (src == 2'd2) begin
      b = {{59{im[4]}}, im};
      s = 1'b0;
    end
    v = s ? (sext66(a, w) - sext66(b, w)) : (sext66(a, w) + sext66(b, w));
    q = v >>> 1;
    case (rm)
      2'd0: inc = v[0];
      2'd1: inc = v[0] & v[1];
      2'd2: inc = 1'b0;
      default: inc = v[0] & ~v[1];
    endcase
    r = q + 66'(inc);
    return sext66(r[63:0], w)[63:0];
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic sub, input logic [1:0] wsel, input logic [1:0] rm,
      input logic [1:0] src, input logic [63:0] a, input logic [63:0] bv,
      input logic [63:0] bs, input logic [4:0] im, input logic [63:0] exp, input string req);
    @(negedge clk);
    op_sub = sub; width_sel = wsel; round_mode = rm; src_sel = src;
    opa = a; opb_vec = bv; opb_scalar = bs; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10", "out_valid after strobe", 64'(out_valid), 64'd1);
    check(result == exp, req, "result", result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    logic [63:0] held;
    logic [63:0] pa [8];
    logic [63:0] pb [8];
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; width_sel = 2'd0;
    round_mode = 2'd0; src_sel = 2'd0; opa = '0; opb_vec = '0; opb_scalar = '0; imm = '0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after release", 64'(out_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].sub, VECS[i].wsel, VECS[i].rm, VECS[i].src, VECS[i].a,
             VECS[i].bv, VECS[i].bs, VECS[i].imm, VECS[i].exp, vec_tag(i));
    end

    // R10: no strobe -> result holds, out_valid low
    held = result;
    opa = 64'h55; opb_vec = 64'h33;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid idle", 64'(out_valid), 64'd0);
    check(result == held, "R10", "result hold", result, held);

    // corner pairs and pseudo-random pairs at every width, mode, direction
    lfsr = 64'hACE1_2468_1357_9BDF;
    for (int w = 0; w < 4; w++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int s = 0; s < 2; s++) begin
          logic [63:0] mx, mn, e;
          int ew;
          ew = 8 << w;
          mx = (64'd1 << (ew - 1)) - 64'd1;
          mn = ~mx;
          pa[0] = mx; pb[0] = mx;
          pa[1] = mn; pb[1] = mn;
          pa[2] = mx; pb[2] = mn;
          pa[3] = mn; pb[3] = mx;
          for (int k = 4; k < 8; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            pa[k] = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            pb[k] = lfsr;
          end
          for (int k = 0; k < 8; k++) begin
            e = ref_avg(1'(s), 2'(w), 2'(rm), 2'd0, pa[k], pb[k], 64'd0, 5'd0);
            run_op(1'(s), 2'(w), 2'(rm), 2'd0, pa[k], pb[k], 64'd0, 5'd0, e, rm_tag(2'(rm)));
          end
        end
      end
    end

    // R9 immediate with op_sub high, negative immediate at 32 bits
    run_op(1'b1, 2'd2, 2'd2, 2'd2, 64'd1, 64'd0, 64'd0, 5'h10,
           ref_avg(1'b0, 2'd2, 2'd2, 2'd2, 64'd1, 64'd0, 64'd0, 5'h10), "R9");

    // R11: asynchronous clear while out_valid is high
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R11", "async clear", 64'(out_valid), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after second release", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule